// File: doc/BRIEF.md
# Register-Mapped GPIO Controller with Per-Pin Interrupts

This block gives software control of up to 32 general-purpose pins through a small word-addressed register bus with separate read and write strobes. Each pin is either an input, sampled through a two-flop synchroniser, or an output driven from a stored value, with a separate output-enable signal for the pad buffer outside the block.

Every pin also feeds an interrupt detector. The detector is configured by three per-pin bits. Together they select level-sensitive detection of either polarity, a single rising or falling edge, or any transition. Edge events are latched until software acknowledges them with a write-one-to-clear register. Level-mode status simply follows the pin. The latched status, masked by a per-pin enable, is combined into one registered interrupt line. A constant identification word tells software whether the any-transition mode exists in this build.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: During and right after reset, all interrupt enables are 0, every pin is an input (direction register all ones, `pin_oe` all zero), the output register is 0 and `irq` is low.
- R2: Word index 1 (byte 0x04) holds the direction bits, 1 = input and 0 = output. `pin_oe[n]` is the inverse of direction bit n. Word index 0 (byte 0x00) write sets `pin_out`. Both take effect on the edge that samples the write.
- R3: A read of word index 0 returns, per pin, the synchronised pin level when the pin is an input and the stored output level when it is an output. Bits at or above NPINS read 0.
- R4: Edge-select bit 0 (word index 6, byte 0x18) selects level mode. Status bit n then follows the active condition one cycle after the synchronised pin: high when the pin is high if polarity bit n (word index 7, byte 0x1C) is 1, and high when the pin is low if it is 0. An acknowledge write has no lasting effect on such a bit.
- R5: Edge-select 1 with any-edge bit 0 latches status on a rising edge (polarity 1) or a falling edge (polarity 0). A transition of the other direction leaves the status bit unchanged.
- R6: Edge-select 1 with any-edge bit 1 (word index 9, byte 0x24) latches status on every transition of the pin.
- R7: Writing word index 5 (byte 0x14) clears each latched edge-mode status bit written as 1. Bits written as 0 are kept.
- R8: Word index 3 (byte 0x0C) reads the status. Word index 4 (byte 0x10) reads status AND enable (word index 2, byte 0x08). `irq` is the registered OR of the pending bits. A pin change is applied before rising edge 1; status sets on rising edge 3 and `irq` rises on rising edge 4.
- R9: If an acknowledge write and a new qualifying edge hit the same pin in the same cycle, the status bit stays set.
- R10: Word index 8 (byte 0x20) reads the constant VERSION. The any-edge register exists only when VERSION is greater than 2; otherwise it reads 0 and the pins use single-edge detection.
- R11: Word indexes above 9 read 0, and writes to them change nothing. Writes to the status, pending and version words change nothing. The acknowledge word reads 0.
- R12: Read data is registered. It appears on `bus_rdata` after the rising edge that samples `bus_rd`, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NPINS | Pad input levels (asynchronous) |
| pin_out | output | NPINS | Output levels toward the pads |
| pin_oe | output | NPINS | Pad output enables, 1 = drive |
| irq | output | 1 | Combined interrupt request |

## Verification
Register writes reach `pin_out`, `pin_oe` and the trigger configuration on the sampling edge. Read data is due one edge after the read strobe, so the bench samples it at the following falling edge. A pin change is only visible in status after three rising edges and on `irq` after four. A directed test samples `irq` after edges three and four. The random part holds each pin pattern for five cycles before it reads back, so every expected value has settled. The acknowledge race is hit by placing the write strobe over the third edge after a pin change, the same edge where the new edge event latches.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int BUS_W = 32;

  // word indexes (byte address / 4); software decodes these
  localparam int WI_VAL  = 0;
  localparam int WI_DIR  = 1;
  localparam int WI_IEN  = 2;
  localparam int WI_STAT = 3;
  localparam int WI_PEND = 4;
  localparam int WI_ACK  = 5;
  localparam int WI_EDGE = 6;
  localparam int WI_POL  = 7;
  localparam int WI_VER  = 8;
  localparam int WI_ANY  = 9;
  localparam int WI_LAST = WI_ANY;

  typedef enum logic [1:0] {
    TRIG_LEVEL  = 2'd0,
    TRIG_SINGLE = 2'd1,
    TRIG_ANY    = 2'd2
  } trig_kind_e;

  typedef struct packed {
    logic edge_sel;
    logic pol;
    logic any_edge;
  } pin_trig_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int NPINS  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] sync_o,
  output logic [NPINS-1:0] prev_o
);
  localparam int DEPTH = STAGES + 1;

  logic [NPINS-1:0] chain [DEPTH];

  genvar s;
  generate
    for (s = 0; s < DEPTH; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= pin_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain[STAGES-1];
  assign prev_o = chain[STAGES];
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] sync_i,
  input  logic [NPINS-1:0] prev_i,
  input  logic [NPINS-1:0] edge_sel,
  input  logic [NPINS-1:0] pol_sel,
  input  logic [NPINS-1:0] any_sel,
  input  logic [NPINS-1:0] ack_i,
  output logic [NPINS-1:0] status_o
);
  genvar n;
  generate
    for (n = 0; n < NPINS; n++) begin : g_pin
      pin_trig_t  cfg;
      trig_kind_e kind;
      logic       rise, fall, hit, active;

      always_comb begin
        cfg.edge_sel = edge_sel[n];
        cfg.pol      = pol_sel[n];
        cfg.any_edge = any_sel[n];
        if (!cfg.edge_sel)     kind = TRIG_LEVEL;
        else if (cfg.any_edge) kind = TRIG_ANY;
        else                   kind = TRIG_SINGLE;
        rise   = sync_i[n] & ~prev_i[n];
        fall   = ~sync_i[n] & prev_i[n];
        active = cfg.pol ? sync_i[n] : ~sync_i[n];
        case (kind)
          TRIG_ANY:    hit = rise | fall;
          TRIG_SINGLE: hit = cfg.pol ? rise : fall;
          default:     hit = 1'b0;
        endcase
      end

      always_ff @(posedge clk) begin
        if (rst)
          status_o[n] <= 1'b0;
        else if (kind == TRIG_LEVEL)
          status_o[n] <= active;
        else
          status_o[n] <= hit | (status_o[n] & ~ack_i[n]);
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_irq_pkg::*;
#(
  parameter int NPINS   = 32,
  parameter int ADDR_W  = 8,
  parameter int VERSION = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  sync_i,
  input  logic [NPINS-1:0]  status_i,
  output logic [NPINS-1:0]  out_q,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  ien_q,
  output logic [NPINS-1:0]  edge_q,
  output logic [NPINS-1:0]  pol_q,
  output logic [NPINS-1:0]  any_q,
  output logic [NPINS-1:0]  ack_o
);
  localparam int IDX_W    = ADDR_W - 2;
  localparam bit HAS_ANY  = (VERSION > 2);

  logic [IDX_W-1:0] idx;
  logic [NPINS-1:0] wbits;
  logic [BUS_W-1:0] rd_next;

  assign idx   = bus_addr[ADDR_W-1:2];
  assign wbits = bus_wdata[NPINS-1:0];

  function automatic logic [BUS_W-1:0] widen(input logic [NPINS-1:0] v);
    logic [BUS_W-1:0] r;
    r = '0;
    r[NPINS-1:0] = v;
    return r;
  endfunction

  function automatic logic hit_word(input logic [IDX_W-1:0] i, input int w);
    return int'(i) == w;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '0;
      dir_q  <= '1;
      ien_q  <= '0;
      edge_q <= '0;
      pol_q  <= '0;
    end else if (bus_wr) begin
      if (hit_word(idx, WI_VAL))  out_q  <= wbits;
      if (hit_word(idx, WI_DIR))  dir_q  <= wbits;
      if (hit_word(idx, WI_IEN))  ien_q  <= wbits;
      if (hit_word(idx, WI_EDGE)) edge_q <= wbits;
      if (hit_word(idx, WI_POL))  pol_q  <= wbits;
    end
  end

  generate
    if (HAS_ANY) begin : g_any
      always_ff @(posedge clk) begin
        if (rst)
          any_q <= '0;
        else if (bus_wr && hit_word(idx, WI_ANY))
          any_q <= wbits;
      end
    end else begin : g_no_any
      assign any_q = '0;
    end
  endgenerate

  assign ack_o = (bus_wr && hit_word(idx, WI_ACK)) ? wbits : '0;

  always_comb begin
    rd_next = '0;
    case (int'(idx))
      WI_VAL:  rd_next = widen((dir_q & sync_i) | (~dir_q & out_q));
      WI_DIR:  rd_next = widen(dir_q);
      WI_IEN:  rd_next = widen(ien_q);
      WI_STAT: rd_next = widen(status_i);
      WI_PEND: rd_next = widen(status_i & ien_q);
      WI_EDGE: rd_next = widen(edge_q);
      WI_POL:  rd_next = widen(pol_q);
      WI_VER:  rd_next = BUS_W'(VERSION);
      WI_ANY:  rd_next = widen(any_q);
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPINS   = 32,
  parameter int ADDR_W  = 8,
  parameter int VERSION = 3,
  parameter int SYNC_ST = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  logic [NPINS-1:0] sync_w, prev_w, status_w;
  logic [NPINS-1:0] out_w, dir_w, ien_w, edge_w, pol_w, any_w, ack_w;

  gpio_sync #(.NPINS(NPINS), .STAGES(SYNC_ST)) u_sync (
    .clk(clk), .rst(rst), .pin_in(pin_in), .sync_o(sync_w), .prev_o(prev_w)
  );

  gpio_regfile #(.NPINS(NPINS), .ADDR_W(ADDR_W), .VERSION(VERSION)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sync_i(sync_w), .status_i(status_w),
    .out_q(out_w), .dir_q(dir_w), .ien_q(ien_w), .edge_q(edge_w),
    .pol_q(pol_w), .any_q(any_w), .ack_o(ack_w)
  );

  gpio_trig_detect #(.NPINS(NPINS)) u_det (
    .clk(clk), .rst(rst), .sync_i(sync_w), .prev_i(prev_w),
    .edge_sel(edge_w), .pol_sel(pol_w), .any_sel(any_w),
    .ack_i(ack_w), .status_o(status_w)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(status_w & ien_w);
  end

  assign pin_out = out_w;
  assign pin_oe  = ~dir_w;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe,
  input logic              irq,
  input logic [NPINS-1:0]  sync_w,
  input logic [NPINS-1:0]  prev_w,
  input logic [NPINS-1:0]  status_w,
  input logic [NPINS-1:0]  ien_w,
  input logic [NPINS-1:0]  edge_w,
  input logic [NPINS-1:0]  pol_w,
  input logic [NPINS-1:0]  any_w
);
  logic [ADDR_W-3:0] widx;
  logic [NPINS-1:0]  any_hit;
  assign widx    = bus_addr[ADDR_W-1:2];
  assign any_hit = edge_w & any_w & (sync_w ^ prev_w);

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    rst |=> (!irq && ien_w == '0 && pin_oe == '0));

  // R2
  dir_to_oe_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && int'(widx) == 1) |=> pin_oe == ~$past(bus_wdata[NPINS-1:0]));

  // R2
  val_to_out_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && int'(widx) == 0) |=> pin_out == $past(bus_wdata[NPINS-1:0]));

  // R4
  level_follow_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (((status_w ^ ~($past(pol_w) ^ $past(sync_w))) & ~$past(edge_w)) == '0));

  // R6
  any_edge_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (any_hit != '0) |=> ((status_w & $past(any_hit)) == $past(any_hit)));

  // R8
  no_enable_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (ien_w == '0) |=> !irq);

  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && int'(widx) > 9) |=> bus_rdata == '0);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out),
  .pin_oe(pin_oe), .irq(irq), .sync_w(sync_w), .prev_w(prev_w),
  .status_w(status_w), .ien_w(ien_w), .edge_w(edge_w), .pol_w(pol_w),
  .any_w(any_w)
);

// File: tb/sim_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_irq_ctrl;
  localparam int N = 32;

  logic        clk = 0;
  logic        rst = 1;
  logic        bus_wr = 0, bus_rd = 0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] pin_in = '0, pin_out, pin_oe;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 0;

  // model state
  logic [N-1:0] m_out, m_dir, m_ien, m_edge, m_pol, m_any, m_stat, m_pins;

  always #2 clk = ~clk;

  gpio_irq_ctrl u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] lvl_cond();
    return ~(m_pol ^ m_pins);
  endfunction
  function automatic logic [31:0] exp_val();
    return (m_dir & m_pins) | (~m_dir & m_out);
  endfunction
  function automatic logic [N-1:0] exp_pend();
    return m_stat & m_ien;
  endfunction

  task automatic bus_write(input int widx, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = 8'(widx * 4); bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic bus_read(input int widx, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = 8'(widx * 4);
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic cfg_write(input int widx, input logic [31:0] d);
    bus_write(widx, d);
    case (widx)
      0: m_out = d; 1: m_dir = d; 2: m_ien = d;
      6: m_edge = d; 7: m_pol = d; 9: m_any = d;
      default: ;
    endcase
    m_stat = (m_stat & m_edge) | (lvl_cond() & ~m_edge);
    repeat (2) @(negedge clk);
  endtask

  task automatic set_pins(input logic [N-1:0] nv);
    logic [N-1:0] rise, fall, ev;
    @(negedge clk);
    pin_in = nv;
    repeat (5) @(negedge clk);
    rise = nv & ~m_pins;
    fall = ~nv & m_pins;
    ev = (m_any & (rise | fall)) | (~m_any & ((m_pol & rise) | (~m_pol & fall)));
    m_pins = nv;
    m_stat = (m_edge & (m_stat | ev)) | (~m_edge & lvl_cond());
  endtask

  task automatic ack(input logic [N-1:0] m);
    bus_write(5, m);
    m_stat = (m_edge & m_stat & ~m) | (~m_edge & lvl_cond());
    repeat (2) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    bus_read(0, d); check({tag, " R3 value"}, d, exp_val());
    bus_read(3, d); check({tag, " R8 status"}, d, m_stat);
    bus_read(4, d); check({tag, " R8 pending"}, d, exp_pend());
    check({tag, " R8 irq"}, {31'd0, irq}, {31'd0, |exp_pend()});
    check({tag, " R2 oe/out"}, pin_oe ^ pin_out, ~m_dir ^ m_out);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    void'($urandom(32'h5eed_0042));
    m_out = '0; m_dir = '1; m_ien = '0; m_edge = '0; m_pol = '0; m_any = '0;
    m_pins = '0;
    // R1: active-low level on every pin with pins at 0
    m_stat = '1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 during reset
    check("R1 irq in reset", {31'd0, irq}, 32'd0);
    check("R1 oe in reset", pin_oe, 32'd0);
    rst = 0;
    repeat (3) @(negedge clk);
    bus_read(2, d); check("R1 enables", d, 32'd0);
    bus_read(1, d); check("R1 direction", d, 32'hFFFF_FFFF);
    check("R1 out", pin_out, 32'd0);
    check_all("R1/R4 reset level");

    // R10 version and any-edge register
    bus_read(8, d); check("R10 version", d, 32'd3);
    cfg_write(9, 32'hA5A5_0F0F);
    bus_read(9, d); check("R10 any-edge readback", d, 32'hA5A5_0F0F);
    cfg_write(9, 32'd0);

    // R11 unmapped / read-only words
    bus_write(10, 32'hFFFF_FFFF);
    bus_write(15, 32'hFFFF_FFFF);
    bus_write(3, 32'd0);
    bus_write(4, 32'd0);
    bus_read(10, d); check("R11 unmapped read", d, 32'd0);
    bus_read(63, d); check("R11 top unmapped read", d, 32'd0);
    bus_read(5, d); check("R11 ack reads zero", d, 32'd0);
    bus_read(8, d); check("R11 version unchanged", d, 32'd3);
    check_all("R11 after ignored writes");

    // R12: read data held between reads
    bus_read(8, d);
    repeat (3) @(negedge clk);
    check("R12 rdata held", bus_rdata, 32'd3);

    // R8 timing: pin0 rising edge, enabled
    cfg_write(6, 32'h1);
    cfg_write(7, 32'h1);
    ack(32'h1);
    cfg_write(2, 32'h1);
    check("R8 irq idle", {31'd0, irq}, 32'd0);
    @(negedge clk); pin_in = 32'h1;
    repeat (3) @(negedge clk);
    check("R8 irq not yet after edge 3", {31'd0, irq}, 32'd0);
    @(negedge clk);
    check("R8 irq after edge 4", {31'd0, irq}, 32'd1);
    m_pins = 32'h1; m_stat[0] = 1'b1;
    check_all("R5 rise latched");

    // R5: falling edge on rising-mode pin leaves status set
    set_pins(32'h0);
    check_all("R5 fall ignored");

    // R9: ack lands on the edge where a new rise latches
    @(negedge clk); pin_in = 32'h1;
    @(negedge clk);
    @(negedge clk);
    bus_wr = 1; bus_addr = 8'h14; bus_wdata = 32'h1;
    @(negedge clk); bus_wr = 0;
    repeat (2) @(negedge clk);
    bus_read(3, d); check("R9 event beats ack", d & 32'h1, 32'h1);
    m_pins = 32'h1;
    // R7: ack without event clears
    ack(32'h1);
    check_all("R7 cleared");

    // R7: zero bits kept
    cfg_write(6, 32'h6);
    cfg_write(9, 32'h6);
    ack(32'h6);
    set_pins(32'h7);
    check_all("R6 both set");
    ack(32'h2);
    check_all("R7 partial ack");
    set_pins(32'h1);
    check_all("R6 falling both");
    cfg_write(9, 32'd0);

    // random phase
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom % 8);
      case (op)
        0: cfg_write(0, $urandom);
        1: cfg_write(1, $urandom);
        2: cfg_write(2, $urandom);
        3: cfg_write(6, $urandom);
        4: cfg_write(7, $urandom);
        5: cfg_write(9, $urandom);
        6: ack($urandom);
        default: set_pins($urandom);
      endcase
      check_all("R4/R5/R6/R7/R8 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule